// File: doc/BRIEF.md
# Power Supply Hiccup Fault Controller

This block is the digital supervisor of a multi-output power controller. It takes comparator results as inputs: an over-current flag for each of two switching outputs, a shared linear-regulator under-voltage flag, an over-voltage flag on the primary output, and one under-voltage-cleared flag per output. Every one of these passes through a two-flop synchronizer. The block models the soft-start ramp as a counter. From that ramp and the flags it drives an output-inhibit line, a ramp-discharge request, a sticky fault line and a power-good line.

An over-current trip inhibits the outputs and counts one strike. The ramp keeps charging until it reaches full scale, then drains quickly. Once the ramp is nearly empty the trip is forgotten and a new soft-start attempt begins. This is hiccup-mode retry. The third strike since power-on latches the controller off. An over-voltage latches it off at once, without using the strike count. The linear under-voltage flag is blanked until the ramp is full. Only the power-on reset clears the strike count and the fault.

Top module: `hiccup_supervisor`

## Requirements
- R1: While and right after power-on reset (rst_n low), inhibit, ss_dis, fault and pgood are 0 and ramp is 0.
- R2: Outside a trip, ramp rises by exactly one on each clock with step_en high. It does not move when step_en is low, and it holds at 2^RAMP_W-1 (full).
- R3: An over-current flag (either bit of oc_flag) held for at least two clocks raises inhibit no later than the third rising edge after it is applied. Each new trip adds one strike.
- R4: After a trip with the ramp below full, inhibit stays high and ss_dis stays low while the ramp keeps charging. ss_dis rises only once the ramp is full. The ramp then falls by DIS_STEP per step_en clock, saturating at 0.
- R5: When the draining ramp is at or below LOW_THR, the trip clears: ss_dis and inhibit fall and charging resumes.
- R6: luv_flag has no effect while the ramp is below full. At full it trips exactly like an over-current.
- R7: The third trip since power-on reset sets fault.
- R8: ov_flag held for two clocks sets fault no later than the third rising edge after it is applied, whatever the strike count.
- R9: fault stays set until power-on reset. While fault is set, inhibit and ss_dis are 1 and the ramp drains to 0.
- R10: pgood is 1 exactly when all synchronized uv_ok bits are 1 and inhibit is 0.
- R11: Power-on reset clears the strike count, so a single trip after reset leaves fault at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (bias supply cycling) |
| step_en | input | 1 | Ramp step enable tick |
| oc_flag | input | 2 | Over-current comparator flags of the two switching outputs |
| luv_flag | input | 1 | Linear-regulator under-voltage comparator flag |
| ov_flag | input | 1 | Primary-output over-voltage comparator flag |
| uv_ok | input | NOUT | Per-output flag: output above its under-voltage level |
| inhibit | output | 1 | Disable all outputs |
| ss_dis | output | 1 | Soft-start ramp discharge request |
| fault | output | 1 | Latched fault, high until power-on reset |
| pgood | output | 1 | Power good |
| ramp | output | RAMP_W | Soft-start ramp level (clamps the error amplifiers) |

## Verification
The assertions assume that comparator flags are level signals held for at least two clocks. Shorter pulses may be lost in the synchronizers, so the properties make no claim about them. The assertions also assume that step_en is the only thing that moves the ramp. The stimulus therefore holds every flag for four clocks or longer, changes inputs only on the falling clock edge, and keeps step_en high except in the one test that checks the ramp freezing. The test that trips the ramp while it is rising releases the flag well before the ramp is full. This way the start of the discharge comes from the ramp reaching full and not from a flag that is still active.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic {
    PH_CHARGE = 1'b0,
    PH_DRAIN  = 1'b1
  } ramp_phase_e;

  // one charge step, holding at the top of the scale
  function automatic int ramp_up(int lvl, int top);
    return (lvl >= top) ? top : lvl + 1;
  endfunction

  // one discharge step, saturating at zero
  function automatic int ramp_down(int lvl, int step);
    return (lvl > step) ? lvl - step : 0;
  endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pipe[s] <= '0;
      else if (s == 0) pipe[s] <= d;
      else             pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/hs_ramp.sv
module hs_ramp #(
  parameter int RAMP_W   = 10,
  parameter int DIS_STEP = 16,
  parameter int LOW_THR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              trip_held,
  input  logic              fault,
  output logic [RAMP_W-1:0] level,
  output logic              up,
  output logic              drained,
  output logic              draining
);
  import hiccup_pkg::*;

  localparam int TOP = (1 << RAMP_W) - 1;

  ramp_phase_e phase;

  assign up       = (int'(level) == TOP);
  assign draining = (phase == PH_DRAIN);
  assign drained  = draining && (int'(level) <= LOW_THR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      phase <= PH_CHARGE;
    end else if (fault) begin
      phase <= PH_CHARGE;
      if (step_en) level <= RAMP_W'(ramp_down(int'(level), DIS_STEP));
    end else begin
      unique case (phase)
        PH_CHARGE: begin
          if (trip_held && up) phase <= PH_DRAIN;
          else if (step_en)    level <= RAMP_W'(ramp_up(int'(level), TOP));
        end
        PH_DRAIN: begin
          if (drained)      phase <= PH_CHARGE;
          else if (step_en) level <= RAMP_W'(ramp_down(int'(level), DIS_STEP));
        end
        default: phase <= PH_CHARGE;
      endcase
    end
  end

endmodule

// File: rtl/hs_strike.sv
module hs_strike #(
  parameter int STRIKES = 3,
  localparam int CNT_W  = $clog2(STRIKES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trip,
  input  logic             ov,
  input  logic             drained,
  output logic             trip_held,
  output logic             trip_new,
  output logic             fault,
  output logic [CNT_W-1:0] strikes
);

  assign trip_new = trip && !trip_held && !fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_held <= 1'b0;
      strikes   <= '0;
      fault     <= 1'b0;
    end else begin
      if (drained)       trip_held <= 1'b0;
      else if (trip_new) trip_held <= 1'b1;

      if (trip_new && (int'(strikes) < STRIKES)) strikes <= strikes + 1'b1;

      if (ov || (trip_new && (int'(strikes) == STRIKES - 1))) fault <= 1'b1;
    end
  end

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int NOUT        = 4,
  parameter int RAMP_W      = 10,
  parameter int DIS_STEP    = 16,
  parameter int LOW_THR     = 3,
  parameter int STRIKES     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [1:0]        oc_flag,
  input  logic              luv_flag,
  input  logic              ov_flag,
  input  logic [NOUT-1:0]   uv_ok,
  output logic              inhibit,
  output logic              ss_dis,
  output logic              fault,
  output logic              pgood,
  output logic [RAMP_W-1:0] ramp
);

  localparam int SYNC_W = NOUT + 4;
  localparam int CNT_W  = $clog2(STRIKES + 1);

  logic [SYNC_W-1:0] flags_s;
  logic [NOUT-1:0]   uv_ok_w;
  logic [1:0]        oc_w;
  logic              luv_w, ov_w;
  logic              oc_any_w, up_w, drained_w, draining_w;
  logic              trip_w, trip_held_w, ocl_set_w, fault_w;
  logic [CNT_W-1:0]  strikes_w;

  hs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   ({ov_flag, luv_flag, oc_flag, uv_ok}),
    .q   (flags_s)
  );

  assign {ov_w, luv_w, oc_w, uv_ok_w} = flags_s;
  assign oc_any_w = |oc_w;
  assign trip_w   = oc_any_w || (luv_w && up_w);

  hs_strike #(.STRIKES(STRIKES)) u_strike (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip      (trip_w),
    .ov        (ov_w),
    .drained   (drained_w),
    .trip_held (trip_held_w),
    .trip_new  (ocl_set_w),
    .fault     (fault_w),
    .strikes   (strikes_w)
  );

  hs_ramp #(.RAMP_W(RAMP_W), .DIS_STEP(DIS_STEP), .LOW_THR(LOW_THR)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .trip_held (trip_held_w),
    .fault     (fault_w),
    .level     (ramp),
    .up        (up_w),
    .drained   (drained_w),
    .draining  (draining_w)
  );

  assign fault   = fault_w;
  assign inhibit = trip_held_w || fault_w;
  assign ss_dis  = draining_w || fault_w;
  assign pgood   = (&uv_ok_w) && !inhibit;

endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk #(
  parameter int RAMP_W  = 10,
  parameter int LOW_THR = 3,
  parameter int STRIKES = 3,
  parameter int CNT_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inhibit,
  input logic              ss_dis,
  input logic              fault,
  input logic              pgood,
  input logic [RAMP_W-1:0] ramp,
  input logic              ocl_set_w,
  input logic              oc_any_w,
  input logic              up_w,
  input logic [CNT_W-1:0]  strikes_w
);

  assert_fault_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_fault_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (inhibit && ss_dis));

  assert_pgood_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> (!inhibit && !fault));

  assert_luv_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_any_w && !up_w) |-> !ocl_set_w);

  assert_charge_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_dis && !fault) |=> (fault || (ramp >= $past(ramp))));

  assert_drain_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_dis) |-> (int'(ramp) <= LOW_THR));

  assert_strike_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(strikes_w) <= STRIKES);

  assert_third_strike_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ocl_set_w && (int'(strikes_w) == STRIKES - 1)) |=> fault);

endmodule

bind hiccup_supervisor hiccup_supervisor_chk #(
  .RAMP_W (RAMP_W),
  .LOW_THR(LOW_THR),
  .STRIKES(STRIKES),
  .CNT_W  (CNT_W)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inhibit  (inhibit),
  .ss_dis   (ss_dis),
  .fault    (fault),
  .pgood    (pgood),
  .ramp     (ramp),
  .ocl_set_w(ocl_set_w),
  .oc_any_w (oc_any_w),
  .up_w     (up_w),
  .strikes_w(strikes_w)
);

// File: tb/hiccup_supervisor_tb_top.sv
module hiccup_supervisor_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NOUT       = 4;
  localparam int RAMP_W     = 10;
  localparam int DIS_STEP   = 16;
  localparam int LOW_THR    = 3;
  localparam int FULL       = (1 << RAMP_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              step_en = 1'b1;
  logic [1:0]        oc_flag = '0;
  logic              luv_flag = 1'b0;
  logic              ov_flag = 1'b0;
  logic [NOUT-1:0]   uv_ok = '0;
  logic              inhibit, ss_dis, fault, pgood;
  logic [RAMP_W-1:0] ramp;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_supervisor #(.NOUT(NOUT), .RAMP_W(RAMP_W), .DIS_STEP(DIS_STEP),
                      .LOW_THR(LOW_THR)) dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .oc_flag(oc_flag),
    .luv_flag(luv_flag), .ov_flag(ov_flag), .uv_ok(uv_ok),
    .inhibit(inhibit), .ss_dis(ss_dis), .fault(fault), .pgood(pgood), .ramp(ramp)
  );

  typedef struct packed {
    logic       luv;
    logic [3:0] uv;
    logic [7:0] wait_n;
    logic       e_inh;
    logic       e_pg;
  } vec_t;

  // early in the first ramp: luv must be blanked, pgood follows uv_ok
  localparam vec_t VECS [7] = '{
    '{1'b0, 4'b0000, 8'd4,  1'b0, 1'b0},
    '{1'b0, 4'b1111, 8'd4,  1'b0, 1'b1},
    '{1'b0, 4'b0111, 8'd4,  1'b0, 1'b0},
    '{1'b1, 4'b1111, 8'd4,  1'b0, 1'b1},
    '{1'b1, 4'b1111, 8'd20, 1'b0, 1'b1},
    '{1'b0, 4'b1011, 8'd4,  1'b0, 1'b0},
    '{1'b0, 4'b1111, 8'd4,  1'b0, 1'b1}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ramp_ge(int v);
    for (int n = 0; n < 5000 && int'(ramp) < v; n++) @(negedge clk);
  endtask

  task automatic wait_ssdis(logic v);
    for (int n = 0; n < 5000 && ss_dis !== v; n++) @(negedge clk);
  endtask

  task automatic pulse_oc(logic [1:0] which);
    oc_flag = which;
    edges(4);
    oc_flag = '0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int r0;
    // R1 reset state
    edges(3);
    check("R1 inhibit", inhibit, 0);
    check("R1 fault", fault, 0);
    check("R1 pgood", pgood, 0);
    check("R1 ss_dis", ss_dis, 0);
    check("R1 ramp", ramp, 0);
    rst_n = 1'b1;

    // table: R6 blanking during the rise, R10 pgood
    foreach (VECS[i]) begin
      luv_flag = VECS[i].luv;
      uv_ok    = VECS[i].uv;
      edges(int'(VECS[i].wait_n));
      check($sformatf("R6 vec%0d inhibit", i), inhibit, VECS[i].e_inh);
      check($sformatf("R10 vec%0d pgood", i), pgood, VECS[i].e_pg);
    end

    // R2 step_en gating and one step per tick
    step_en = 1'b0;
    r0 = int'(ramp);
    edges(10);
    check("R2 ramp frozen", ramp, r0);
    step_en = 1'b1;
    edges(10);
    check("R2 ramp +10", ramp, r0 + 10);

    // R2 hold at full
    wait_ramp_ge(FULL);
    edges(10);
    check("R2 ramp full", ramp, FULL);
    check("R2 no inhibit", inhibit, 0);

    // strike 1: luv at full trips (R6), drain follows at once
    luv_flag = 1'b1;
    edges(4);
    luv_flag = 1'b0;
    check("R6 luv trip inhibit", inhibit, 1);
    check("R10 pgood low", pgood, 0);
    check("R4 ss_dis at full", ss_dis, 1);
    wait_ssdis(1'b0);
    check("R5 ramp low", int'(ramp) <= LOW_THR, 1);
    check("R5 inhibit cleared", inhibit, 0);
    check("R10 pgood back", pgood, 1);
    check("R7 no fault after 1", fault, 0);

    // strike 2: trip while rising keeps charging (R4)
    wait_ramp_ge(200);
    pulse_oc(2'b01);
    check("R3 oc trip inhibit", inhibit, 1);
    check("R4 no drain below full", ss_dis, 0);
    r0 = int'(ramp);
    edges(20);
    check("R4 keeps charging", ramp, r0 + 20);
    check("R4 still inhibited", inhibit, 1);
    wait_ssdis(1'b1);
    check("R4 drain starts at full", ramp, FULL);
    edges(1);
    check("R4 drain step", ramp, FULL - DIS_STEP);
    wait_ssdis(1'b0);
    check("R5 inhibit cleared 2", inhibit, 0);
    check("R7 no fault after 2", fault, 0);

    // strike 3: fault (R7), sticky (R9)
    wait_ramp_ge(FULL);
    pulse_oc(2'b10);
    check("R7 third strike fault", fault, 1);
    check("R9 inhibit in fault", inhibit, 1);
    check("R10 pgood in fault", pgood, 0);
    edges(300);
    check("R9 fault sticky", fault, 1);
    check("R9 ss_dis in fault", ss_dis, 1);
    check("R9 ramp drained", ramp, 0);

    // R11 power-on reset clears strikes and fault
    rst_n = 1'b0;
    edges(3);
    check("R1 reset fault", fault, 0);
    check("R1 reset ramp", ramp, 0);
    rst_n = 1'b1;
    wait_ramp_ge(50);
    pulse_oc(2'b01);
    check("R11 trip after reset inhibit", inhibit, 1);
    check("R11 no fault after reset", fault, 0);

    // R8 over-voltage bypasses the strike count
    ov_flag = 1'b1;
    edges(4);
    ov_flag = 1'b0;
    check("R8 ov fault", fault, 1);
    check("R8 ov inhibit", inhibit, 1);

    finish_run();
  end

endmodule